// File: doc/BRIEF.md
# Dual-Mode Limit Counter Timer

This block is a memory-mapped counter/timer with one interrupt output. It has a small word-addressed register bus and runs from a fixed 500 ns tick that a prescaler derives from the core clock. Every tick adds one unit of 512 to the visible count, so the nine lowest count bits always read as zero.

In system mode the count climbs toward a programmable 31-bit limit. When the count reaches the limit, the block sets a reached flag, raises the interrupt and starts again from zero. Software reads the limit back to acknowledge the event. A second limit address changes the limit without disturbing the count in progress.

An external mode input selects user mode. In user mode the same storage acts as a 64-bit free-running counter that software can stop, restart and zero, and no interrupt is raised. When the mode input changes, the count restarts from zero.

Top module: `limit_timer`

## Requirements
- R1: After reset, the read at index 1 returns 0 and the read at index 0 returns 0x7FFFFE00. The read at index 3 returns 1 and irq_o is low. Internal state leaves reset on the second clock edge after rst_ni rises.
- R2: The count grows by 0x200 once every CLK_HZ/TICK_HZ core cycles, counted from the last restart. Bits 8:0 of any count read are zero.
- R3: In system mode, a write to index 0 does three things. It sets the limit to the written data ANDed with 0x7FFFFE00, or to 0x7FFFFE00 when that result is zero. It zeroes the count. It lowers irq_o.
- R4: A write to index 2 sets the limit by the same masking and zero rule as R3, and the count keeps its value.
- R5: In system mode, when a tick would bring the count to the limit or past it, the count becomes zero, the reached flag is set and irq_o goes high on the same edge.
- R6: In system mode, a read of index 0 returns {0, limit bits 30:0}. It also clears the reached flag and irq_o. If a tick reaches the limit on the same edge, the flag and irq_o stay set.
- R7: In system mode, a read of index 1 returns {reached, count bits 30:9, nine zero bits}.
- R8: In user mode the count is 64 bits wide. Index 0 reads bits 63:32 and index 1 reads bits 31:0. A write to index 0 or index 1 zeroes the count.
- R9: In user mode, a write to index 3 sets the running state to bit 0 of the data. A stopped count holds its value. A read of index 3 returns the running state in bit 0, in either mode.
- R10: In user mode, irq_o stays low.
- R11: A change of user_mode_i restarts the block on the next edge. The count becomes zero, the limit becomes 0x7FFFFE00, the reached flag is cleared and the block is running.
- R12: Writes at index 1 or index 3 in system mode change nothing. Writes at index 4 and above change nothing in either mode. Reads at index 4 and above return 0.
- R13: Read data appears on rd_data_o after the edge that samples rd_en_i. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| user_mode_i | input | 1 | 1 selects the 64-bit user counter, 0 selects the system limit timer |
| addr_i | input | ADDR_W | Byte address; bits above bit 1 give the word index |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; reads at index 0 have a side effect |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Limit-reached interrupt |

## Verification
The terminal tick that sets the reached flag can land on the same edge as a limit read that clears it. The set must win, or an event is lost. To provoke this, the limit is programmed to a single tick, so every tick wraps and flags. The limit address is then read on every cycle for a long stretch, so some reads land exactly on tick edges. At each cycle irq_o and each returned word are compared with a bench model that applies the set-over-clear priority, and random bursts of limit reads against small random limits repeat the collision at other phases.

// File: rtl/ltmr_pkg.sv
`timescale 1ns/1ps
package ltmr_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned FRAC_W = 9;
  localparam int unsigned FULL_W = 64;
  localparam int unsigned TICK_W = FULL_W - FRAC_W - 1;
  localparam int unsigned SYS_W  = WORD_W - FRAC_W - 1;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_LIM      = 3'd0,
    REG_CNT      = 3'd1,
    REG_LIM_HOLD = 3'd2,
    REG_CTRL     = 3'd3,
    REG_MODESEL  = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic             load_lim;
    logic             clr_cnt;
    logic             set_lim;
    logic             set_run;
    logic             run_val;
    logic             rd_ack;
    logic [SYS_W-1:0] lim_val;
  } bus_cmd_t;

  // Limit in tick units; an all-zero field selects the largest limit.
  function automatic logic [SYS_W-1:0] sys_limit_fix(input logic [WORD_W-1:0] w);
    logic [SYS_W-1:0] v;
    v = w[WORD_W-2:FRAC_W];
    return (v == '0) ? {SYS_W{1'b1}} : v;
  endfunction

endpackage

// File: rtl/ltmr_prescale.sv
`timescale 1ns/1ps
module ltmr_prescale #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);

  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;

  assign tick_o = (phase_q == LAST);

  always_comb begin
    phase_d = phase_q;
    if (clear_i || tick_o) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2: ticks are isolated single-cycle pulses
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o)
        else $error("tick pulse longer than one cycle");
    end
  endgenerate

endmodule

// File: rtl/ltmr_core.sv
`timescale 1ns/1ps
module ltmr_core
  import ltmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              tick_i,
  input  bus_cmd_t          cmd_i,
  output logic              restart_o,
  output logic              user_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic [SYS_W-1:0]  lim_o,
  output logic              reached_o,
  output logic              run_o
);

  localparam logic [SYS_W-1:0]  SYS_MAX = {SYS_W{1'b1}};
  localparam logic [TICK_W-1:0] USR_MAX = {TICK_W{1'b1}};

  logic              mode_q;
  logic [TICK_W-1:0] ticks_q, ticks_d, ticks_inc;
  logic [SYS_W-1:0]  lim_q, lim_d;
  logic              reached_q, reached_d;
  logic              run_q, run_d;
  logic              mode_chg, restart, step, sys_hit, usr_wrap;

  assign mode_chg  = mode_i ^ mode_q;
  assign restart   = mode_chg | cmd_i.load_lim | cmd_i.clr_cnt;
  assign step      = tick_i & run_q & ~restart;
  assign ticks_inc = ticks_q + 1'b1;
  assign sys_hit   = ~mode_q & (ticks_inc >= TICK_W'(lim_q));
  assign usr_wrap  = mode_q & (ticks_q == USR_MAX);

  always_comb begin
    ticks_d   = ticks_q;
    lim_d     = lim_q;
    reached_d = reached_q;
    run_d     = run_q;
    if (step) begin
      if (sys_hit) begin
        ticks_d   = '0;
        reached_d = 1'b1;
      end else if (usr_wrap) begin
        ticks_d = '0;
      end else begin
        ticks_d = ticks_inc;
      end
    end
    if (mode_chg) begin
      ticks_d   = '0;
      lim_d     = SYS_MAX;
      reached_d = 1'b0;
      run_d     = 1'b1;
    end else begin
      if (cmd_i.load_lim || cmd_i.clr_cnt) begin
        ticks_d   = '0;
        reached_d = 1'b0;
      end
      if (cmd_i.load_lim || cmd_i.set_lim) begin
        lim_d = cmd_i.lim_val;
      end
      if (cmd_i.set_run) begin
        run_d = cmd_i.run_val;
      end
      if (cmd_i.rd_ack && !(step && sys_hit)) begin
        reached_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      ticks_q   <= '0;
      lim_q     <= SYS_MAX;
      reached_q <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      mode_q    <= mode_i;
      ticks_q   <= ticks_d;
      lim_q     <= lim_d;
      reached_q <= reached_d;
      run_q     <= run_d;
    end
  end

  assign restart_o = restart;
  assign user_o    = mode_q;
  assign ticks_o   = ticks_q;
  assign lim_o     = lim_q;
  assign reached_o = reached_q;
  assign run_o     = run_q;

  // R2: the count only steps by one tick or returns to zero
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ticks_q != $past(ticks_q)) |-> (ticks_q == '0 || ticks_q == $past(ticks_q) + 1'b1))
    else $error("count jumped");

  // R3: the limit register never holds zero
  p_limit_nz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_q != '0)
    else $error("zero limit stored");

  // R5: a newly raised reached flag comes with a zero count
  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reached_q) |-> (ticks_q == '0))
    else $error("reached set without wrap");

  // R9: a stopped counter holds its value
  p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_q) && !$past(restart)) |-> (ticks_q == $past(ticks_q)))
    else $error("stopped counter moved");

  // R10: no reached flag while in user mode
  p_user_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !reached_q)
    else $error("flag raised in user mode");

  // R11: a mode change restarts the block
  p_mode_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_chg) |-> (ticks_q == '0 && lim_q == SYS_MAX && run_q && !reached_q))
    else $error("mode change did not restart");

endmodule

// File: rtl/ltmr_regif.sv
`timescale 1ns/1ps
module ltmr_regif
  import ltmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              user_i,
  input  logic [TICK_W-1:0] ticks_i,
  input  logic [SYS_W-1:0]  lim_i,
  input  logic              reached_i,
  input  logic              run_i,
  output bus_cmd_t          cmd_o,
  output logic [WORD_W-1:0] rd_data_o
);

  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              hit_lim, hit_cnt, hit_hold, hit_ctrl;
  logic [FULL_W-1:0] full;
  logic [WORD_W-1:0] rd_d, rd_q;
  logic              unused_bits;

  assign idx      = addr_i[ADDR_W-1:2];
  assign hit_lim  = (idx == IW'(REG_LIM));
  assign hit_cnt  = (idx == IW'(REG_CNT));
  assign hit_hold = (idx == IW'(REG_LIM_HOLD));
  assign hit_ctrl = (idx == IW'(REG_CTRL));
  assign unused_bits = ^{addr_i[1:0], wr_data_i[WORD_W-1], wr_data_i[FRAC_W-1:1]};

  assign full = {1'b0, ticks_i, {FRAC_W{1'b0}}};

  always_comb begin
    cmd_o          = '0;
    cmd_o.load_lim = wr_en_i & hit_lim & ~user_i;
    cmd_o.clr_cnt  = wr_en_i & (hit_lim | hit_cnt) & user_i;
    cmd_o.set_lim  = wr_en_i & hit_hold;
    cmd_o.set_run  = wr_en_i & hit_ctrl & user_i;
    cmd_o.run_val  = wr_data_i[0];
    cmd_o.rd_ack   = rd_en_i & hit_lim & ~user_i;
    cmd_o.lim_val  = sys_limit_fix(wr_data_i);
  end

  always_comb begin
    rd_d = '0;
    if (hit_lim) begin
      rd_d = user_i ? full[FULL_W-1:WORD_W] : {1'b0, lim_i, {FRAC_W{1'b0}}};
    end else if (hit_cnt) begin
      rd_d = user_i ? full[WORD_W-1:0]
                    : {reached_i, ticks_i[SYS_W-1:0], {FRAC_W{1'b0}}};
    end else if (hit_ctrl) begin
      rd_d = {{(WORD_W-1){1'b0}}, run_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  // R2: count words never carry sub-tick bits
  p_frac_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && (hit_lim || hit_cnt)) |-> (rd_data_o[FRAC_W-1:0] == '0))
    else $error("low count bits not zero");

  // R13: read data holds between reads
  p_rd_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rd_data_o))
    else $error("read data changed without a read");

endmodule

// File: rtl/limit_timer.sv
`timescale 1ns/1ps
module limit_timer
  import ltmr_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 2_000_000,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              user_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);

  localparam int unsigned DIV = (CLK_HZ / TICK_HZ > 0) ? (CLK_HZ / TICK_HZ) : 1;

  logic              rst_s1_q, rst_s2_q;
  logic              tick, restart, user;
  logic [TICK_W-1:0] ticks;
  logic [SYS_W-1:0]  lim;
  logic              reached, run;
  bus_cmd_t          cmd;

  // asynchronous assertion, release after two edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  ltmr_prescale #(.DIV(DIV)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_s2_q),
    .clear_i (restart),
    .tick_o  (tick)
  );

  ltmr_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_s2_q),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .user_i    (user),
    .ticks_i   (ticks),
    .lim_i     (lim),
    .reached_i (reached),
    .run_i     (run),
    .cmd_o     (cmd),
    .rd_data_o (rd_data_o)
  );

  ltmr_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_s2_q),
    .mode_i    (user_mode_i),
    .tick_i    (tick),
    .cmd_i     (cmd),
    .restart_o (restart),
    .user_o    (user),
    .ticks_o   (ticks),
    .lim_o     (lim),
    .reached_o (reached),
    .run_o     (run)
  );

  assign irq_o = reached;

endmodule

// File: tb/limit_timer_tb.sv
`timescale 1ns/1ps
module limit_timer_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DIV        = 4;
  localparam logic [21:0] LMAX       = '1;
  localparam logic [53:0] UMAX       = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_drv = 1'b0;
  logic [4:0]  addr_drv = '0;
  logic        wr_drv = 1'b0;
  logic [31:0] wd_drv = '0;
  logic        rd_drv = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_timer #(.CLK_HZ(8_000_000), .TICK_HZ(2_000_000), .ADDR_W(5)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .user_mode_i (mode_drv),
    .addr_i      (addr_drv),
    .wr_en_i     (wr_drv),
    .wr_data_i   (wd_drv),
    .rd_en_i     (rd_drv),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  // ---------------- reference model ----------------
  logic [53:0] m_t;
  logic [21:0] m_l;
  logic        m_r, m_run, m_mode;
  logic [31:0] m_rd;
  int unsigned m_p;
  logic        b_s1, b_s2;

  function automatic logic [21:0] fix_lim(input logic [31:0] w);
    return (w[30:9] == '0) ? LMAX : w[30:9];
  endfunction

  function automatic logic [31:0] exp_read(input int ix, input logic u);
    logic [63:0] full;
    full = {1'b0, m_t, 9'b0};
    case (ix)
      0: return u ? full[63:32] : {1'b0, m_l, 9'b0};
      1: return u ? full[31:0] : {m_r, m_t[21:0], 9'b0};
      3: return {31'b0, m_run};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_reset();
    m_t = '0; m_l = LMAX; m_r = 1'b0; m_run = 1'b1;
    m_mode = 1'b0; m_rd = '0; m_p = 0;
  endfunction

  function automatic void m_step();
    logic chg, u, rs, tk, hit;
    int ix;
    logic [53:0] nt;
    logic [21:0] nl;
    logic nr, nrun;
    chg = (mode_drv != m_mode);
    u   = m_mode;
    ix  = int'(addr_drv[4:2]);
    rs  = chg || (wr_drv && (ix == 0 || (ix == 1 && u)));
    tk  = (m_p == DIV-1) && !rs;
    if (rd_drv) m_rd = exp_read(ix, u);
    nt = m_t; nl = m_l; nr = m_r; nrun = m_run; hit = 1'b0;
    if (tk && m_run) begin
      if (!u && ({10'b0, m_t} + 64'd1 >= {42'b0, m_l})) begin nt = '0; hit = 1'b1; end
      else if (u && m_t == UMAX) nt = '0;
      else nt = m_t + 1'b1;
    end
    if (chg) begin
      nt = '0; nl = LMAX; nr = 1'b0; nrun = 1'b1;
    end else begin
      if (wr_drv && ix == 0) begin nt = '0; nr = 1'b0; if (!u) nl = fix_lim(wd_drv); end
      if (wr_drv && ix == 1 && u) begin nt = '0; nr = 1'b0; end
      if (wr_drv && ix == 2) nl = fix_lim(wd_drv);
      if (wr_drv && ix == 3 && u) nrun = wd_drv[0];
      if (hit) nr = 1'b1;
      else if (rd_drv && ix == 0 && !u) nr = 1'b0;
    end
    m_p = rs ? 0 : ((m_p == DIV-1) ? 0 : m_p + 1);
    m_t = nt; m_l = nl; m_r = nr; m_run = nrun; m_mode = mode_drv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_s1 = 1'b0; b_s2 = 1'b0;
      m_reset();
    end else begin
      if (!b_s2) m_reset();
      else m_step();
      b_s2 = b_s1;
      b_s1 = 1'b1;
    end
  end

  // ---------------- checking ----------------
  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic string tag_of(input int ix, input logic u);
    if (ix >= 4) return "R12";
    if (ix == 3) return "R9";
    if (u) return "R8";
    return (ix == 0) ? "R6" : "R7";
  endfunction

  // R5 / R10: interrupt follows the model on every cycle
  always @(negedge clk) begin
    if (b_s2 && !done) chk(m_mode ? "R10 irq" : "R5 irq", {31'b0, irq}, {31'b0, m_r});
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wr(input int ix, input logic [31:0] d);
    addr_drv = 5'(ix << 2); wd_drv = d; wr_drv = 1'b1;
    cyc();
    wr_drv = 1'b0;
  endtask

  task automatic do_rd(input int ix, output logic [31:0] v);
    logic u;
    u = m_mode;
    addr_drv = 5'(ix << 2); rd_drv = 1'b1;
    cyc();
    rd_drv = 1'b0;
    v = rd_data;
    chk(tag_of(ix, u), rd_data, m_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    int seed_dummy;
    seed_dummy = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    do_rd(1, v); chk("R1 count", v, 32'h0);
    do_rd(0, v); chk("R1 limit", v, 32'h7FFFFE00);
    do_rd(3, v); chk("R1 running", v, 32'h1);

    // R3 zero limit / R2 tick rate
    do_wr(0, 32'h0);
    repeat (39) cyc();
    do_rd(1, v); chk("R2 count rate", v, 32'h00001200);
    chk("R2 low bits", {23'b0, v[8:0]}, 32'h0);
    do_rd(0, v); chk("R3 zero gives max", v, 32'h7FFFFE00);

    // R3 masking and count reset
    do_wr(0, 32'h8000_0C37);
    do_rd(1, v); chk("R3 count zeroed", v, 32'h0);
    do_rd(0, v); chk("R3 masked limit", v, 32'h00000C00);

    // R5 / R7 / R6 limit event
    do_wr(0, 32'h0000_0C00);
    repeat (23) cyc();
    chk("R5 before limit", {31'b0, irq}, 32'h0);
    cyc();
    chk("R5 at limit", {31'b0, irq}, 32'h1);
    do_rd(1, v); chk("R7 reached word", v, 32'h80000000);
    do_rd(0, v); chk("R6 limit read", v, 32'h00000C00);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);

    // R4 limit update keeps count
    do_wr(0, 32'h0000_1000);
    repeat (12) cyc();
    do_wr(2, 32'h0);
    do_rd(1, v); chk("R4 count kept", v, 32'h00000600);
    do_rd(0, v); chk("R4 limit max", v, 32'h7FFFFE00);

    // R12 ignored accesses in system mode
    do_wr(0, 32'h0000_1000);
    repeat (5) cyc();
    do_wr(1, 32'h0);
    do_rd(1, v); chk("R12 count not reset", v, 32'h00000200);
    do_wr(3, 32'h0);
    do_rd(3, v); chk("R12 run unchanged", v, 32'h1);
    do_wr(4, 32'hFFFF_FFFF);
    do_rd(4, v); chk("R12 idx4 reads zero", v, 32'h0);
    do_rd(5, v); chk("R12 idx5 reads zero", v, 32'h0);

    // R13 read data holds
    do_rd(0, v1);
    repeat (5) cyc();
    chk("R13 hold", rd_data, v1);

    // collision: one-tick limit, read limit every cycle (R6 priority)
    do_wr(0, 32'h0000_0200);
    addr_drv = 5'd0; rd_drv = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc();
      chk("R6 collision read", rd_data, m_rd);
    end
    rd_drv = 1'b0;
    cyc();

    // R11 / R8 / R9 / R10 user mode
    mode_drv = 1'b1;
    cyc();
    do_rd(1, v); chk("R11 count zero", v, 32'h0);
    do_rd(0, v); chk("R8 upper word", v, 32'h0);
    do_rd(3, v); chk("R11 running", v, 32'h1);
    repeat (20) cyc();
    do_wr(3, 32'h0);
    do_rd(1, v1);
    repeat (20) cyc();
    do_rd(1, v); chk("R9 stopped holds", v, v1);
    do_rd(3, v); chk("R9 stopped state", v, 32'h0);
    do_wr(3, 32'h1);
    repeat (12) cyc();
    do_rd(1, v);
    do_wr(1, 32'hDEAD_BEEF);
    do_rd(1, v); chk("R8 write resets", v, 32'h0);
    do_wr(0, 32'h1234_5678);
    do_rd(1, v); chk("R8 idx0 write resets", v, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    mode_drv = 1'b0;
    cyc();
    do_rd(0, v); chk("R11 back to max", v, 32'h7FFFFE00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 16);
      if (op <= 6) begin
        do_rd(int'($urandom % 8), v);
      end else if (op <= 10) begin
        logic [31:0] d;
        d = ($urandom % 2 == 0) ? (($urandom % 8) << 9) : $urandom;
        do_wr(int'($urandom % 8), d);
      end else if (op <= 13) begin
        repeat (1 + $urandom % 6) cyc();
      end else if (op == 14) begin
        if ($urandom % 3 == 0) mode_drv = ~mode_drv;
        cyc();
      end else begin
        addr_drv = 5'd0; rd_drv = 1'b1;
        for (int k = 0; k < 8; k++) begin
          logic u;
          u = m_mode;
          cyc();
          chk(tag_of(0, u), rd_data, m_rd);
        end
        rd_drv = 1'b0;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule